// File: doc/BRIEF.md
# EUI-64 Identification Record Generator and Checker

This block turns a 24-bit company identifier and a 40-bit extension identifier into a fixed 32-byte identification record and streams it out one byte per accepted transfer. It can also take in a 32-byte record and judge whether it is well formed. The record is laid out in this order:

- a length code;
- a fixed 4-byte project code;
- the 64-bit EUI;
- an inverted CRC16 protecting the first thirteen bytes;
- filler up to the end of the page.

The generator runs after a single-cycle start pulse. Each byte is offered with `out_valid` and moves on when `out_ready` is high. The checker path is separate and can run at the same time. For each byte it accepts while `in_valid` is high, it updates its own CRC. When the last byte of a page arrives, it reports one flag for each class of defect and the 64-bit identifier it pulled from the record.

Top module: `eui_rec_engine`

## Requirements
- R1: After reset, `out_valid`, `busy`, `chk_done`, `err_len`, `err_crc` and `err_pad` are all low.
- R2: A one-cycle `start` while `busy` is low raises `busy` and `out_valid` on the next edge, and the first byte offered (position 0) is the length code 0Ch.
- R3: Positions 1 to 4 carry the project code 00001128h with its low byte first: 28h, 11h, 00h, 00h.
- R4: Positions 5 to 12 carry the EUI-64 (company identifier in bits 63:40, extension identifier in bits 39:0), with the least significant byte at position 5.
- R5: Positions 13 and 14 carry the bitwise complement of a CRC16 taken over positions 0 to 12, low byte at 13 and high byte at 14. The CRC starts at 0000h, shifts each byte in least significant bit first, and uses the reflected polynomial A001h (x^16+x^15+x^2+1). For company 006035h and extension 234567ABCDh the two bytes are FFh and 3Eh.
- R6: Positions 15 to 31 are FFh.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values.
- R8: `busy` stays high until position 31 has been accepted and is low on the following cycle. A `start` pulse while `busy` is high has no effect on the record being sent.
- R9: `chk_done` pulses for exactly one cycle, on the edge after the 32nd `in_valid` byte. Cycles with `in_valid` low do not count toward the 32.
- R10: `err_len` is high at `chk_done` exactly when the checked position 0 differs from 0Ch.
- R11: `err_crc` is high at `chk_done` exactly when position 13 or 14 differs from the inverted CRC16 (as in R5) of the checked positions 0 to 12.
- R12: `err_pad` is high at `chk_done` exactly when any checked position 15 to 31 differs from FFh.
- R13: At `chk_done`, `eui_out` holds the checked positions 5 to 12 reassembled with position 5 as the least significant byte. The flags and `eui_out` hold until the next `chk_done`.
- R14: The generator and the checker run independently. Feeding the generator's accepted bytes into the checker during the same cycles yields a clean check whose `eui_out` equals the generated EUI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a record |
| company_id | input | 24 | Company identifier, upper part of the EUI |
| ext_id | input | 40 | Extension identifier, lower part of the EUI |
| out_valid | output | 1 | Generated byte is available |
| out_data | output | 8 | Generated record byte |
| out_ready | input | 1 | Consumer accepts the byte |
| busy | output | 1 | Record in progress |
| in_valid | input | 1 | Byte to check is present |
| in_data | input | 8 | Record byte to check |
| chk_done | output | 1 | One-cycle pulse: check result ready |
| err_len | output | 1 | Length code mismatch |
| err_crc | output | 1 | CRC bytes mismatch |
| err_pad | output | 1 | Filler byte mismatch |
| eui_out | output | 64 | Identifier taken from the checked record |

## Verification
The generator and the checker can both accept a byte on the same clock edge. Each also updates its own CRC on that edge.

To provoke this, the bench loops the generator's accepted bytes straight into the checker input. Generation and checking then advance in lockstep, and the checker reaches its last byte on the edge where the generator finishes. The result is judged by a clean `chk_done` whose `eui_out` equals the identifier the bench supplied.

Separate runs with a stalled consumer, with gaps in the input and with one byte corrupted at a time show that neither path borrows state from the other.

// File: rtl/eui_rec_pkg.sv
`timescale 1ns/1ps
package eui_rec_pkg;
  localparam int          REC_BYTES_DEF = 32;
  localparam logic [7:0]  LEN_CODE      = 8'h0C;
  localparam logic [31:0] PROJ_CODE     = 32'h0000_1128;
  localparam logic [7:0]  FILL_BYTE     = 8'hFF;
  localparam logic [15:0] CRC_REFL_POLY = 16'hA001;
  localparam int          POS_PROJ      = 1;
  localparam int          POS_EUI       = 5;

  // One byte through the reflected CRC, least significant bit first.
  function automatic logic [15:0] crc_byte(input logic [15:0] c,
                                           input logic [7:0]  d,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ poly;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eui_crc16_acc.sv
`timescale 1ns/1ps
module eui_crc16_acc
  import eui_rec_pkg::*;
#(
  parameter logic [15:0] POLY = CRC_REFL_POLY
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_q
);
  logic [15:0] seed;
  assign seed = clr ? 16'h0000 : crc_q;

  // With clr and en together, the byte is folded into a fresh 0000h seed.
  always_ff @(posedge clk) begin
    if (rst)      crc_q <= 16'h0000;
    else if (en)  crc_q <= crc_byte(seed, din, POLY);
    else if (clr) crc_q <= 16'h0000;
  end
endmodule

// File: rtl/eui_rec_gen.sv
`timescale 1ns/1ps
module eui_rec_gen
  import eui_rec_pkg::*;
#(
  parameter int REC_BYTES = REC_BYTES_DEF,
  parameter int EUI_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [8*EUI_BYTES-1:0] eui_in,
  output logic                   out_valid,
  output logic [7:0]             out_data,
  input  logic                   out_ready,
  output logic                   busy
);
  localparam int IDX_W  = $clog2(REC_BYTES);
  localparam int CRC_LO = POS_EUI + EUI_BYTES;
  localparam int CRC_HI = CRC_LO + 1;
  localparam int LAST   = REC_BYTES - 1;

  logic [IDX_W-1:0]       idx;
  logic [8*EUI_BYTES-1:0] eui_q;
  logic [15:0]            crc_q;
  logic                   launch, take;

  assign launch = start && !busy;
  assign take   = out_valid && out_ready;

  eui_crc16_acc #(.POLY(CRC_REFL_POLY)) crc_i (
    .clk(clk), .rst(rst), .clr(launch),
    .en(take && (int'(idx) < CRC_LO)),
    .din(out_data), .crc_q(crc_q)
  );

  // Byte decode from registered state; the CRC is final once position CRC_LO is reached.
  always_comb begin
    int n;
    n = int'(idx);
    if (n == 0)                 out_data = LEN_CODE;
    else if (n < POS_EUI)       out_data = 8'(PROJ_CODE >> (8*(n-POS_PROJ)));
    else if (n < CRC_LO)        out_data = 8'(eui_q >> (8*(n-POS_EUI)));
    else if (n == CRC_LO)       out_data = ~crc_q[7:0];
    else if (n == CRC_HI)       out_data = ~crc_q[15:8];
    else                        out_data = FILL_BYTE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      eui_q     <= '0;
      out_valid <= 1'b0;
      busy      <= 1'b0;
    end else if (launch) begin
      idx       <= '0;
      eui_q     <= eui_in;
      out_valid <= 1'b1;
      busy      <= 1'b1;
    end else if (take) begin
      if (int'(idx) == LAST) begin
        out_valid <= 1'b0;
        busy      <= 1'b0;
        idx       <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_first_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_data == LEN_CODE));
  p_busy_locks_eui_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(eui_q));
endmodule

// File: rtl/eui_rec_chk.sv
`timescale 1ns/1ps
module eui_rec_chk
  import eui_rec_pkg::*;
#(
  parameter int REC_BYTES = REC_BYTES_DEF,
  parameter int EUI_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   chk_done,
  output logic                   err_len,
  output logic                   err_crc,
  output logic                   err_pad,
  output logic [8*EUI_BYTES-1:0] eui_out
);
  localparam int IDX_W  = $clog2(REC_BYTES);
  localparam int EUI_W  = 8*EUI_BYTES;
  localparam int CRC_LO = POS_EUI + EUI_BYTES;
  localparam int CRC_HI = CRC_LO + 1;
  localparam int LAST   = REC_BYTES - 1;

  logic [IDX_W-1:0] idx;
  logic [15:0]      crc_q;
  logic             len_acc, crc_acc, pad_acc;
  logic             len_n, crc_n, pad_n;
  logic [EUI_W-1:0] eui_acc, eui_n;
  logic             first;

  assign first = (idx == '0);

  eui_crc16_acc #(.POLY(CRC_REFL_POLY)) crc_i (
    .clk(clk), .rst(rst), .clr(first),
    .en(in_valid && (int'(idx) < CRC_LO)),
    .din(in_data), .crc_q(crc_q)
  );

  always_comb begin
    int n;
    n     = int'(idx);
    len_n = (!first && len_acc) || (first && (in_data != LEN_CODE));
    crc_n = (!first && crc_acc)
          || ((n == CRC_LO) && (in_data != ~crc_q[7:0]))
          || ((n == CRC_HI) && (in_data != ~crc_q[15:8]));
    pad_n = (!first && pad_acc) || ((n > CRC_HI) && (in_data != FILL_BYTE));
    eui_n = ((n >= POS_EUI) && (n < CRC_LO)) ? {in_data, eui_acc[EUI_W-1:8]} : eui_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      len_acc  <= 1'b0;
      crc_acc  <= 1'b0;
      pad_acc  <= 1'b0;
      eui_acc  <= '0;
      chk_done <= 1'b0;
      err_len  <= 1'b0;
      err_crc  <= 1'b0;
      err_pad  <= 1'b0;
      eui_out  <= '0;
    end else begin
      chk_done <= 1'b0;
      if (in_valid) begin
        len_acc <= len_n;
        crc_acc <= crc_n;
        pad_acc <= pad_n;
        eui_acc <= eui_n;
        if (int'(idx) == LAST) begin
          idx      <= '0;
          chk_done <= 1'b1;
          err_len  <= len_n;
          err_crc  <= crc_n;
          err_pad  <= pad_n;
          eui_out  <= eui_n;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    chk_done |=> !chk_done);
  p_done_needs_byte_r9: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> $past(in_valid));
  p_flags_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !chk_done |-> ($stable(err_len) && $stable(err_crc) && $stable(err_pad) && $stable(eui_out)));
  p_len_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && first && (in_data != LEN_CODE)) |=> len_acc);
endmodule

// File: rtl/eui_rec_engine.sv
`timescale 1ns/1ps
module eui_rec_engine
  import eui_rec_pkg::*;
#(
  parameter int COMP_W    = 24,
  parameter int EXT_W     = 40,
  parameter int REC_BYTES = REC_BYTES_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [COMP_W-1:0]         company_id,
  input  logic [EXT_W-1:0]          ext_id,
  output logic                      out_valid,
  output logic [7:0]                out_data,
  input  logic                      out_ready,
  output logic                      busy,
  input  logic                      in_valid,
  input  logic [7:0]                in_data,
  output logic                      chk_done,
  output logic                      err_len,
  output logic                      err_crc,
  output logic                      err_pad,
  output logic [COMP_W+EXT_W-1:0]   eui_out
);
  localparam int EUI_W     = COMP_W + EXT_W;
  localparam int EUI_BYTES = EUI_W / 8;

  logic [EUI_W-1:0] eui_cat;
  assign eui_cat = {company_id, ext_id};

  eui_rec_gen #(.REC_BYTES(REC_BYTES), .EUI_BYTES(EUI_BYTES)) gen_i (
    .clk(clk), .rst(rst), .start(start), .eui_in(eui_cat),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .busy(busy)
  );

  eui_rec_chk #(.REC_BYTES(REC_BYTES), .EUI_BYTES(EUI_BYTES)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .chk_done(chk_done), .err_len(err_len), .err_crc(err_crc),
    .err_pad(err_pad), .eui_out(eui_out)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !busy && !chk_done));
endmodule

// File: tb/eui_rec_engine_tb_top.sv
`timescale 1ns/1ps
module eui_rec_engine_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, out_ready = 1'b0;
  logic [23:0] company_id = '0;
  logic [39:0] ext_id = '0;
  logic        out_valid, busy, chk_done, err_len, err_crc, err_pad;
  logic [7:0]  out_data;
  logic [63:0] eui_out;
  logic        loop = 1'b0, tb_in_valid = 1'b0;
  logic [7:0]  tb_in_data = '0;
  logic        in_valid;
  logic [7:0]  in_data;

  assign in_valid = loop ? (out_valid & out_ready) : tb_in_valid;
  assign in_data  = loop ? out_data : tb_in_data;

  eui_rec_engine dut_i (
    .clk(clk), .rst(rst), .start(start), .company_id(company_id), .ext_id(ext_id),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .busy(busy),
    .in_valid(in_valid), .in_data(in_data), .chk_done(chk_done),
    .err_len(err_len), .err_crc(err_crc), .err_pad(err_pad), .eui_out(eui_out)
  );

  int total = 0, bad = 0;
  logic [7:0] rec [32];
  logic [7:0] got [32];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [63:0] eui);
    logic [7:0]  bytes [13];
    logic [15:0] c;
    logic        fb;
    bytes[0] = 8'h0C; bytes[1] = 8'h28; bytes[2] = 8'h11; bytes[3] = 8'h00; bytes[4] = 8'h00;
    for (int k = 0; k < 8; k++) bytes[5+k] = eui[8*k +: 8];
    c = 16'h0000;
    for (int k = 0; k < 13; k++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ bytes[k][b];
        c  = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'hA001;
      end
    return c;
  endfunction

  task automatic build_rec(input logic [63:0] eui);
    logic [15:0] c;
    c = ~ref_crc(eui);
    rec[0] = 8'h0C; rec[1] = 8'h28; rec[2] = 8'h11; rec[3] = 8'h00; rec[4] = 8'h00;
    for (int k = 0; k < 8; k++) rec[5+k] = eui[8*k +: 8];
    rec[13] = c[7:0];
    rec[14] = c[15:8];
    for (int k = 15; k < 32; k++) rec[k] = 8'hFF;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !busy && !chk_done && !err_len && !err_crc && !err_pad,
          "R1 reset state", {58'd0, out_valid, busy, chk_done, err_len, err_crc, err_pad}, 64'd0);
  endtask

  // stall=1 applies back-pressure and a stray start pulse mid-record
  task automatic t_gen(input logic [23:0] comp, input logic [39:0] ext, input bit stall);
    int cnt, cyc;
    bit prev_stall;
    logic [7:0] prev_data;
    logic [63:0] eui;
    eui = {comp, ext};
    build_rec(eui);
    company_id = comp; ext_id = ext;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && out_valid && out_data == 8'h0C, "R2 start gives length byte",
          {54'd0, busy, out_valid, out_data}, {54'd0, 2'b11, 8'h0C});
    cnt = 0; cyc = 0; prev_stall = 0; prev_data = '0;
    while (cnt < 32 && cyc < 2000) begin
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R7 hold during stall",
              {55'd0, out_valid, out_data}, {55'd0, 1'b1, prev_data});
      if (stall && cyc == 5) begin
        check(busy, "R8 busy mid record", {63'd0, busy}, 64'd1);
        start = 1'b1; company_id = 24'hABCDEF; ext_id = 40'h1122334455;
      end else begin
        start = 1'b0;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        got[cnt] = out_data;
        cnt++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; out_ready = 1'b0;
    check(!busy && !out_valid, "R8 busy falls after last byte",
          {62'd0, busy, out_valid}, 64'd0);
    for (int k = 0; k < 32; k++) begin
      string tag;
      if (k == 0)       tag = "R2 length";
      else if (k < 5)   tag = "R3 project code";
      else if (k < 13)  tag = "R4 eui byte";
      else if (k < 15)  tag = "R5 inverted crc";
      else              tag = "R6 fill";
      check(got[k] == rec[k], $sformatf("%s pos %0d", tag, k), {56'd0, got[k]}, {56'd0, rec[k]});
    end
    company_id = comp; ext_id = ext;
  endtask

  task automatic t_feed(input bit gaps, input bit e_len, input bit e_crc, input bit e_pad,
                        input logic [63:0] e_eui, input string name);
    for (int k = 0; k < 32; k++) begin
      if (gaps && (k % 5 == 2)) begin
        @(negedge clk); tb_in_valid = 1'b0; tb_in_data = 8'h00;
      end
      @(negedge clk); tb_in_valid = 1'b1; tb_in_data = rec[k];
    end
    @(negedge clk); tb_in_valid = 1'b0;
    check(chk_done, {"R9 done pulse ", name}, {63'd0, chk_done}, 64'd1);
    check(err_len == e_len, {"R10 len flag ", name}, {63'd0, err_len}, {63'd0, e_len});
    check(err_crc == e_crc, {"R11 crc flag ", name}, {63'd0, err_crc}, {63'd0, e_crc});
    check(err_pad == e_pad, {"R12 pad flag ", name}, {63'd0, err_pad}, {63'd0, e_pad});
    check(eui_out == e_eui, {"R13 eui out ", name}, eui_out, e_eui);
    @(negedge clk);
    check(!chk_done, {"R9 single cycle ", name}, {63'd0, chk_done}, 64'd0);
    check(err_crc == e_crc && eui_out == e_eui, {"R13 flags hold ", name},
          {63'd0, err_crc}, {63'd0, e_crc});
  endtask

  task automatic t_checks();
    logic [63:0] e;
    e = 64'h0123456789ABCDEF;
    build_rec(e);
    t_feed(1'b1, 1'b0, 1'b0, 1'b0, e, "clean with gaps");
    build_rec(e); rec[0] = 8'h0D;
    t_feed(1'b0, 1'b1, 1'b1, 1'b0, e, "bad length");
    build_rec(e); rec[14] = rec[14] ^ 8'h01;
    t_feed(1'b0, 1'b0, 1'b1, 1'b0, e, "bad crc high");
    build_rec(e); rec[9] = rec[9] ^ 8'h80;
    t_feed(1'b0, 1'b0, 1'b1, 1'b0, e ^ (64'h80 << 32), "bad eui byte");
    build_rec(e); rec[31] = 8'hFE;
    t_feed(1'b0, 1'b0, 1'b0, 1'b1, e, "bad last fill");
  endtask

  task automatic t_loopback(input logic [23:0] comp, input logic [39:0] ext);
    int cyc;
    loop = 1'b1;
    company_id = comp; ext_id = ext;
    @(negedge clk); start = 1'b1; out_ready = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!chk_done && cyc < 200) begin
      @(negedge clk); cyc++;
    end
    check(chk_done, "R14 concurrent check completes", {63'd0, chk_done}, 64'd1);
    check(!err_len && !err_crc && !err_pad, "R14 concurrent check clean",
          {61'd0, err_len, err_crc, err_pad}, 64'd0);
    check(eui_out == {comp, ext}, "R14 concurrent eui", eui_out, {comp, ext});
    check(!busy, "R14 generator idle at check end", {63'd0, busy}, 64'd0);
    out_ready = 1'b0; loop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_gen(24'h006035, 40'h234567ABCD, 1'b0);
    check(got[13] == 8'hFF && got[14] == 8'h3E, "R5 example crc bytes",
          {48'd0, got[14], got[13]}, {48'd0, 8'h3E, 8'hFF});
    t_gen(24'hFEDCBA, 40'h00FF00FF01, 1'b1);
    t_checks();
    t_loopback(24'h006035, 40'h0000000001);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule